// File: doc/BRIEF.md
# Half-Integer Clock Divider (divide by 4.5) with Consumer Source Select

This block turns a fast, undivided source clock into a clock at the source frequency divided by 4.5. Nine source half-periods make one output period, so the block counts on both edges of the source. A flop on the rising edge and a flop on the falling edge each form one of the two pulses in a pair of output periods. The output is high for four half-periods and low for five, a duty cycle of 44.4% rather than 50%.

The same source also feeds an ordinary integer divider, by 3 by default. One consumer is fed from a small mux. A select input asks for the half-integer clock and an enable input turns the half-integer divider on. The consumer gets the half-integer clock only while both are set, and otherwise gets the integer clock. The applied choice is held in a register. It changes only where the clock being left ends a period, and the clock being joined restarts its period on that same edge, so no runt pulse reaches the consumer.

All inputs are assumed synchronous to the source clock. The integer part of the half-integer ratio is a parameter and must be even.

Top module: `half_div_top`

## Requirements
- R1: `half_clk_o` repeats every 9 source half-periods (4.5 source cycles). Its first period starts at the first rising source edge that samples `half_en` high.
- R2: Within each period, `half_clk_o` is high for the first 4 half-periods and low for the next 5, counted from the period start.
- R3: While `half_en` is low, the half-integer counter is held. `half_clk_o` is low from the half-period after the first rising edge that samples `half_en` low, and stays low.
- R4: `int_clk_o` divides the source by 3. It is high for the first source cycle of each period and low for the other two, and it changes on rising edges.
- R5: While `sel_state_o` is 0, `cons_clk_o` follows `int_clk_o`.
- R6: `sel_state_o` rises only on a rising edge that samples `half_sel` and `half_en` both high, and only where `int_clk_o` starts a new period. On that edge the half-integer clock restarts its period, and `cons_clk_o` follows it from there.
- R7: After `half_sel` drops while `half_en` stays high, `sel_state_o` falls on the rising edge that starts every second half-integer period. The integer clock restarts its period on that edge with its high phase.
- R8: A rising edge that samples `half_en` low while `sel_state_o` is 1 clears `sel_state_o`. The integer clock restarts on that edge, so `cons_clk_o` is high for the following source cycle.
- R9: `half_sel` has no effect while `half_en` is low: `sel_state_o` stays 0.
- R10: Reset is synchronous and active-low. It clears `sel_state_o`, `half_clk_o`, `int_clk_o` and `cons_clk_o`. The first integer period starts on the first rising edge that samples `rst_n` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Undivided source clock; both edges are used |
| rst_n | input | 1 | Synchronous active-low reset |
| half_en | input | 1 | Turns the half-integer divider on |
| half_sel | input | 1 | Asks for the half-integer clock at the consumer |
| half_clk_o | output | 1 | Source clock divided by 4.5, 44.4% duty cycle |
| int_clk_o | output | 1 | Source clock divided by 3 |
| cons_clk_o | output | 1 | Clock delivered to the consumer |
| sel_state_o | output | 1 | Applied choice: 1 means the half-integer clock |

## Verification
Every output is a register. A rising edge that samples a new enable, select or reset sets the rising-edge half of the outputs right after that edge. The falling-edge flop of the half-integer clock follows one half-period later, so checks of a disabled clock skip the first half-period. A select change waits for the next period end of the clock being left: up to 3 source cycles towards the half-integer clock, and up to 9 towards the integer clock. The bench samples each half-period 1.25 ns after the edge that starts it. The driver finds the switching edge by watching `sel_state_o`, then queues the expected waveform half-period by half-period from that edge. The monitor pops one expected entry per half-period and compares it.

// File: rtl/half_div_pkg.sv
// Shared types for the half-integer divider block.
// Assumes nothing beyond IEEE 1800-2017 enums.
package half_div_pkg;
    // Which divided clock the consumer mux passes on.
    typedef enum logic {
        SRC_INT  = 1'b0,
        SRC_HALF = 1'b1
    } clk_pick_e;
endpackage

// File: rtl/half_div_core.sv
// Half-integer divider: divides the source by DIV_INT + 0.5.
// One counter on the rising edge walks 2*DIV_INT+1 full cycles, which is two output periods.
// A rising-edge flop forms the pulse of the even period and a falling-edge flop forms the
// pulse of the odd period. The output is their OR.
// Assumes DIV_INT is even, so each pulse is DIV_INT half-periods wide.
module half_div_core #(
    parameter int DIV_INT = 4
) (
    input  logic clk_src,
    input  logic rst_n,
    input  logic en,
    input  logic restart,
    output logic wrap_o,
    output logic clk_o
);
    localparam int CNT_MAX = 2 * DIV_INT;
    localparam int PAIRS   = DIV_INT / 2;
    localparam int CW      = $clog2(CNT_MAX + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;
    logic          rise_q;
    logic          fall_q;

    // Next count: parked at the last value while off, so the first enabled edge starts at 0.
    always_comb begin
        if (!en) begin
            cnt_nxt = CW'(CNT_MAX);
        end else if (restart || (cnt_q == CW'(CNT_MAX))) begin
            cnt_nxt = '0;
        end else begin
            cnt_nxt = cnt_q + CW'(1);
        end
    end

    // Full-cycle counter on the rising edge.
    always_ff @(posedge clk_src) begin
        if (!rst_n) begin
            cnt_q <= CW'(CNT_MAX);
        end else begin
            cnt_q <= cnt_nxt;
        end
    end

    // Pulse of the even period: high over the first PAIRS full cycles.
    always_ff @(posedge clk_src) begin
        if (!rst_n) begin
            rise_q <= 1'b0;
        end else begin
            rise_q <= en && (cnt_nxt < CW'(PAIRS));
        end
    end

    // Pulse of the odd period: starts half a cycle into count DIV_INT.
    always_ff @(negedge clk_src) begin
        if (!rst_n) begin
            fall_q <= 1'b0;
        end else begin
            fall_q <= (cnt_q >= CW'(DIV_INT)) && (cnt_q < CW'(DIV_INT + PAIRS));
        end
    end

    // Wrap flag and output waveform.
    always_comb begin
        wrap_o = en && (cnt_q == CW'(CNT_MAX));
        clk_o  = rise_q | fall_q;
    end
endmodule

// File: rtl/int_div_core.sv
// Integer divider: divides the source by INT_DIV.
// The output is high for the first INT_DIV/2 cycles of each period and changes on rising edges.
// A restart pulse begins a new period on the next edge.
// Assumes INT_DIV >= 2.
module int_div_core #(
    parameter int INT_DIV = 3
) (
    input  logic clk_src,
    input  logic rst_n,
    input  logic restart,
    output logic wrap_o,
    output logic clk_o
);
    localparam int LAST    = INT_DIV - 1;
    localparam int INT_HIGH = INT_DIV / 2;
    localparam int IW      = (INT_DIV > 2) ? $clog2(INT_DIV) : 1;

    logic [IW-1:0] ic_q;
    logic [IW-1:0] ic_nxt;
    logic          out_q;

    // Next count with wrap or forced restart.
    always_comb begin
        if (restart || (ic_q == IW'(LAST))) begin
            ic_nxt = '0;
        end else begin
            ic_nxt = ic_q + IW'(1);
        end
    end

    // Counter and registered output; the reset value makes the first edge start a period.
    always_ff @(posedge clk_src) begin
        if (!rst_n) begin
            ic_q  <= IW'(LAST);
            out_q <= 1'b0;
        end else begin
            ic_q  <= ic_nxt;
            out_q <= ic_nxt < IW'(INT_HIGH);
        end
    end

    // Period-end flag and output.
    always_comb begin
        wrap_o = (ic_q == IW'(LAST));
        clk_o  = out_q;
    end
endmodule

// File: rtl/clk_pick_ctrl.sv
// Consumer source controller. It holds the applied choice in a register and changes it only
// where the clock being left ends a period. It also tells the divider being joined to restart
// on that edge. A disabled half-integer divider counts as ended at every edge.
// Assumes half_sel and half_en are synchronous to clk_src.
module clk_pick_ctrl
    import half_div_pkg::*;
(
    input  logic      clk_src,
    input  logic      rst_n,
    input  logic      half_sel,
    input  logic      half_en,
    input  logic      half_wrap,
    input  logic      int_wrap,
    output clk_pick_e pick_o,
    output logic      to_half_o,
    output logic      to_int_o
);
    clk_pick_e pick_q;
    logic      want_half;
    logic      at_end;
    logic      do_switch;

    // Requested choice and whether this edge may apply it.
    always_comb begin
        want_half = half_sel && half_en;
        at_end    = (pick_q == SRC_HALF) ? (half_wrap || !half_en) : int_wrap;
        do_switch = at_end && (want_half != (pick_q == SRC_HALF));
        to_half_o = do_switch && want_half;
        to_int_o  = do_switch && !want_half;
        pick_o    = pick_q;
    end

    // Applied choice register.
    always_ff @(posedge clk_src) begin
        if (!rst_n) begin
            pick_q <= SRC_INT;
        end else if (do_switch) begin
            pick_q <= want_half ? SRC_HALF : SRC_INT;
        end
    end
endmodule

// File: rtl/half_div_top.sv
// Top of the divider block. It holds the half-integer divider, the integer divider, the
// source controller and the consumer mux. The mux input only changes at edges where the
// clock being left has just ended a period and the clock being joined restarts.
// Assumes the inputs are synchronous to clk_src and HALF_INT is even.
module half_div_top
    import half_div_pkg::*;
#(
    parameter int HALF_INT = 4,
    parameter int INT_DIV  = 3
) (
    input  logic clk_src,
    input  logic rst_n,
    input  logic half_en,
    input  logic half_sel,
    output logic half_clk_o,
    output logic int_clk_o,
    output logic cons_clk_o,
    output logic sel_state_o
);
    clk_pick_e pick;
    logic      half_wrap;
    logic      int_wrap;
    logic      to_half;
    logic      to_int;
    logic      half_clk;
    logic      int_clk;

    half_div_core #(.DIV_INT(HALF_INT)) half_i (
        .clk_src (clk_src),
        .rst_n   (rst_n),
        .en      (half_en),
        .restart (to_half),
        .wrap_o  (half_wrap),
        .clk_o   (half_clk)
    );

    int_div_core #(.INT_DIV(INT_DIV)) int_i (
        .clk_src (clk_src),
        .rst_n   (rst_n),
        .restart (to_int),
        .wrap_o  (int_wrap),
        .clk_o   (int_clk)
    );

    clk_pick_ctrl pick_i (
        .clk_src   (clk_src),
        .rst_n     (rst_n),
        .half_sel  (half_sel),
        .half_en   (half_en),
        .half_wrap (half_wrap),
        .int_wrap  (int_wrap),
        .pick_o    (pick),
        .to_half_o (to_half),
        .to_int_o  (to_int)
    );

    // Consumer mux and output wiring.
    always_comb begin
        cons_clk_o  = (pick == SRC_HALF) ? half_clk : int_clk;
        half_clk_o  = half_clk;
        int_clk_o   = int_clk;
        sel_state_o = (pick == SRC_HALF);
    end
endmodule

// File: rtl/half_div_chk.sv
// Protocol checker for half_div_top, attached with bind. Watches ports only.
module half_div_chk (
    input logic clk_src,
    input logic rst_n,
    input logic half_en,
    input logic half_sel,
    input logic half_clk_o,
    input logic int_clk_o,
    input logic sel_state_o
);
    // R3
    half_off_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
        $past(!half_en) |-> !half_clk_o);

    // R6
    to_half_edge_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
        $rose(sel_state_o) |-> $past(!int_clk_o));

    // R6
    to_half_req_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
        $rose(sel_state_o) |-> $past(half_sel && half_en));

    // R7
    to_int_edge_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
        $fell(sel_state_o) |-> $past(!half_clk_o || !half_en));

    // R8
    drop_en_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
        (sel_state_o && !half_en) |=> !sel_state_o);

    // R9
    sel_ignored_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
        !half_en |=> !$rose(sel_state_o));
endmodule

bind half_div_top half_div_chk chk_i (
    .clk_src     (clk_src),
    .rst_n       (rst_n),
    .half_en     (half_en),
    .half_sel    (half_sel),
    .half_clk_o  (half_clk_o),
    .int_clk_o   (int_clk_o),
    .sel_state_o (sel_state_o)
);

// File: tb/half_div_top_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues the expected waveform per source half-period and the
// monitor compares one entry per half-period, 1.25 ns after the edge that starts it.
module half_div_top_tb_top;
    logic clk_src  = 1'b0;
    logic rst_n    = 1'b0;
    logic half_en  = 1'b0;
    logic half_sel = 1'b0;
    logic half_clk_o;
    logic int_clk_o;
    logic cons_clk_o;
    logic sel_state_o;

    typedef struct {
        int kh;
        int ki;
        int kc;
    } item_t;

    item_t q[$];
    int    n_chk  = 0;
    int    n_fail = 0;
    bit    mon_on = 1'b0;
    bit    done   = 1'b0;
    string tag_h  = "R1";
    string tag_i  = "R4";
    string tag_c  = "R5";

    always #2.5 clk_src = ~clk_src;

    half_div_top dut_i (
        .clk_src     (clk_src),
        .rst_n       (rst_n),
        .half_en     (half_en),
        .half_sel    (half_sel),
        .half_clk_o  (half_clk_o),
        .int_clk_o   (int_clk_o),
        .cons_clk_o  (cons_clk_o),
        .sel_state_o (sel_state_o)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Half-integer pattern: high for the first 4 of every 9 half-periods.
    function automatic int hp(input int h);
        return ((h % 9) < 4) ? 1 : 0;
    endfunction

    // Integer pattern: high for the first of every 3 source cycles.
    function automatic int ip(input int h);
        return (((h / 2) % 3) == 0) ? 1 : 0;
    endfunction

    task automatic push(input int kh, input int ki, input int kc);
        item_t it;
        it.kh = kh;
        it.ki = ki;
        it.kc = kc;
        q.push_back(it);
    endtask

    task automatic drain();
        while (q.size() > 0) @(posedge clk_src);
        mon_on = 1'b0;
    endtask

    task automatic wait_sel(input logic lvl, input int lim, input string req);
        int  n    = 0;
        bit  seen = 1'b0;
        while (!seen && n < lim) begin
            @(posedge clk_src);
            #0.5;
            n++;
            if (sel_state_o === lvl) seen = 1'b1;
        end
        chk(req, seen, 1'b1);
    endtask

    // Monitor: one comparison per source half-period.
    always begin
        @(clk_src);
        #1.25;
        if (mon_on && q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            if (it.kh >= 0) chk(tag_h, half_clk_o, it.kh[0]);
            if (it.ki >= 0) chk(tag_i, int_clk_o, it.ki[0]);
            if (it.kc >= 0) chk(tag_c, cons_clk_o, it.kc[0]);
        end
    end

    // Watchdog.
    initial begin
        #750000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R10 reset state
        repeat (3) @(posedge clk_src);
        #0.5;
        chk("R10", half_clk_o, 1'b0);
        chk("R10", int_clk_o, 1'b0);
        chk("R10", cons_clk_o, 1'b0);
        chk("R10", sel_state_o, 1'b0);
        // R10 / R4 / R5 / R3: release, integer clock from the first edge, half clock idle
        @(negedge clk_src) rst_n = 1'b1;
        @(posedge clk_src);
        tag_h = "R3"; tag_i = "R4"; tag_c = "R5";
        for (int h = 0; h < 24; h++) push(0, ip(h), ip(h));
        mon_on = 1'b1;
        drain();

        // R1 / R2: enable the half-integer divider
        @(negedge clk_src) half_en = 1'b1;
        @(posedge clk_src);
        tag_h = "R1,R2";
        for (int h = 0; h < 36; h++) push(hp(h), -1, -1);
        mon_on = 1'b1;
        drain();

        // R6: select the half-integer clock
        @(negedge clk_src) half_sel = 1'b1;
        wait_sel(1'b1, 4, "R6");
        chk("R6", int_clk_o, 1'b1);
        tag_h = "R2"; tag_c = "R6";
        for (int h = 0; h < 27; h++) push(hp(h), -1, hp(h));
        mon_on = 1'b1;
        drain();

        // R7: release the select
        @(negedge clk_src) half_sel = 1'b0;
        wait_sel(1'b0, 12, "R7");
        chk("R7", half_clk_o, 1'b1);
        chk("R7", int_clk_o, 1'b1);
        tag_h = "R1"; tag_i = "R4"; tag_c = "R7";
        for (int h = 0; h < 18; h++) push(hp(h), ip(h), ip(h));
        mon_on = 1'b1;
        drain();

        // R8: drop the enable while selected
        @(negedge clk_src) half_sel = 1'b1;
        wait_sel(1'b1, 4, "R6");
        repeat (3) @(posedge clk_src);
        @(negedge clk_src) half_en = 1'b0;
        @(posedge clk_src);
        #0.5;
        chk("R8", sel_state_o, 1'b0);
        tag_h = "R3"; tag_i = "R4"; tag_c = "R8";
        for (int h = 0; h < 16; h++) push((h == 0) ? -1 : 0, ip(h), ip(h));
        mon_on = 1'b1;
        drain();

        // R9: select held high with the enable low is ignored
        for (int i = 0; i < 12; i++) begin
            @(posedge clk_src);
            #0.5;
            chk("R9", sel_state_o, 1'b0);
            chk("R5", cons_clk_o, int_clk_o);
            chk("R3", half_clk_o, 1'b0);
        end

        // R6: enable with the select already set
        @(negedge clk_src) half_en = 1'b1;
        wait_sel(1'b1, 4, "R6");
        chk("R6", int_clk_o, 1'b1);
        tag_h = "R2"; tag_c = "R6";
        for (int h = 0; h < 18; h++) push(hp(h), -1, hp(h));
        mon_on = 1'b1;
        drain();

        // R10: reset during operation
        @(negedge clk_src) rst_n = 1'b0;
        @(posedge clk_src);
        #0.5;
        chk("R10", sel_state_o, 1'b0);
        chk("R10", int_clk_o, 1'b0);
        @(negedge clk_src);
        #0.5;
        chk("R10", half_clk_o, 1'b0);
        chk("R10", cons_clk_o, 1'b0);
        half_sel = 1'b0;
        half_en  = 1'b0;
        @(negedge clk_src) rst_n = 1'b1;
        @(posedge clk_src);
        #0.5;
        chk("R10", int_clk_o, 1'b1);
        @(posedge clk_src);
        #0.5;
        chk("R4", int_clk_o, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule